// File: doc/BRIEF.md
# ULPI Link Inter-Packet Delay Timer

This block belongs to the link side of a ULPI controller. It watches the bus direction, stop and next-data strobes, together with the already decoded receive-command fields (line state and receive-active). From these it finds the bus event that opens each inter-packet gap, and it counts ULPI clocks from that event. It then raises a transmit-permitted flag once the minimum gap for the current speed and packet pairing has passed. The transmit state machine of the link holds off its next transmit command until that flag is high.

The reference event depends on speed. In high speed, the gap after a link transmit starts where the link raises STP. The gap after a receive starts where the receive ends. In full and low speed, both pairings count from the receive command that reports the line moving from SE0 to J. A second counter runs after every link transmit and pulses a response timeout when no receive has begun within the limit for the speed. That pulse also releases the transmit gate. A third monitor flags a receive packet that starts too soon after the previous receive ended.

Top module: `ulpi_ipd_timer`

## Requirements
- R1: While `rst_n` is low, `tx_permit`, `resp_timeout` and `rx_gap_short` are all 0. On the first clock edge with `rst_n` high, `tx_permit` rises.
- R2: In high speed, a link transmit end (`ulpi_stp` high while `ulpi_dir` is low) drops `tx_permit` at that edge. `tx_permit` rises exactly 15 clocks after it.
- R3: In high speed, a receive end drops nothing further and raises `tx_permit` exactly 1 clock later. A receive end is `ulpi_dir` falling during a receive, or a receive command with `rxcmd_rxactive` = 0 during a receive.
- R4: In full or low speed, a transmit end or receive end leaves `tx_permit` low until a receive command reports a line state change from SE0 (`00`) to J (`01`). `tx_permit` then rises exactly 7 clocks (full speed) or 77 clocks (low speed) after that command.
- R5: `speed_mode` encodes `00` high, `01` full, `10` low and `11` high speed. The gap length and timeout limit are taken from `speed_mode` at the event that starts them. A later change of `speed_mode` does not alter them.
- R6: Once high, `tx_permit` stays high until the next transmit end, receive start, receive end or (in full and low speed) SE0-to-J event.
- R7: A receive start drops `tx_permit` on the next edge. A receive start is `ulpi_dir` rising with `ulpi_nxt` high, or a receive command with `rxcmd_rxactive` = 1 while no receive is in progress. `ulpi_dir` rising with `ulpi_nxt` low is not a receive start.
- R8: After a transmit end with no following receive start, `resp_timeout` pulses for exactly one clock. The pulse comes 92 (high), 80 (full) or 718 (low) clocks after the transmit end. `tx_permit` is high in that cycle even if the gap event never came.
- R9: A receive start before the timeout limit cancels the response timer, and no `resp_timeout` pulse follows.
- R10: `rx_gap_short` pulses for one clock after a receive start that comes fewer than `RR_MIN_GAP` clocks after the previous receive end. It stays low when the separation is at least `RR_MIN_GAP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ulpi_dir | input | 1 | Bus direction, high while the PHY drives data |
| ulpi_stp | input | 1 | Stop strobe driven by the link |
| ulpi_nxt | input | 1 | Next-data strobe from the PHY |
| rxcmd_valid | input | 1 | A receive command byte is present this cycle |
| rxcmd_linestate | input | 2 | Decoded line state of that command (00 SE0, 01 J) |
| rxcmd_rxactive | input | 1 | Decoded receive-active bit of that command |
| speed_mode | input | 2 | Bus speed: 00 high, 01 full, 10 low, 11 high |
| tx_permit | output | 1 | The link may drive its next transmit command |
| resp_timeout | output | 1 | One-clock pulse: no response after a transmit |
| rx_gap_short | output | 1 | One-clock pulse: receive packets too close together |

## Verification
A wrong gap counter or a wrong latched limit shows up as `tx_permit` rising one or more clocks off the expected count. A missed reference event shows as `tx_permit` never rising in full or low speed until the response timeout releases it, 80 or 718 clocks late. A response timer that fails to cancel shows as a stray `resp_timeout` pulse at most 718 clocks after the transmit end. A wrong receive-in-progress state shows as `tx_permit` staying high through a receive, or as false `rx_gap_short` pulses on the next receive. The bench therefore measures every rise time in clocks for all four speed codes and for each of the three gap event types, sweeps the timeout for every speed, and probes the receive-to-receive monitor at separations on both sides of the limit.

// File: rtl/ulpi_ipd_pkg.sv
// Package: shared types and helpers for the ULPI inter-packet delay timer.
// Assumes: speed code 2'b11 is an alias of high speed.
package ulpi_ipd_pkg;

    typedef enum logic [1:0] {
        SPD_HS     = 2'b00,
        SPD_FS     = 2'b01,
        SPD_LS     = 2'b10,
        SPD_HS_ALT = 2'b11
    } speed_e;

    localparam logic [1:0] LINE_SE0 = 2'b00;
    localparam logic [1:0] LINE_J   = 2'b01;

    // One-cycle bus events found by the decoder
    typedef struct packed {
        logic rx_start;
        logic rx_end;
        logic tx_end;
        logic se0_j;
    } bus_ev_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_high_speed(input logic [1:0] spd);
        return (spd == SPD_HS) || (spd == SPD_HS_ALT);
    endfunction

endpackage

// File: rtl/ulpi_ipd_evdec.sv
// Module: bus event decoder.
// Turns the ULPI strobes and decoded receive commands into one-cycle events:
// receive start, receive end, link transmit end and SE0-to-J line change.
// Assumes: rxcmd_* fields are only valid when rxcmd_valid is high.
module ulpi_ipd_evdec
    import ulpi_ipd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ulpi_dir,
    input  logic       ulpi_stp,
    input  logic       ulpi_nxt,
    input  logic       rxcmd_valid,
    input  logic [1:0] rxcmd_linestate,
    input  logic       rxcmd_rxactive,
    output bus_ev_t    ev
);

    logic       dir_q;
    logic       rx_busy_q;
    logic [1:0] line_q;
    logic       dir_rise;
    logic       dir_fall;

    assign dir_rise = ulpi_dir && !dir_q;
    assign dir_fall = !ulpi_dir && dir_q;

    // Purpose: classify this cycle's bus activity into events
    always_comb begin
        ev.rx_start = !rx_busy_q &&
                      ((dir_rise && ulpi_nxt) || (rxcmd_valid && rxcmd_rxactive));
        ev.rx_end   = rx_busy_q &&
                      (dir_fall || (rxcmd_valid && !rxcmd_rxactive));
        ev.tx_end   = ulpi_stp && !ulpi_dir && !rx_busy_q;
        ev.se0_j    = rxcmd_valid && (rxcmd_linestate == LINE_J) && (line_q == LINE_SE0);
    end

    // Purpose: remember direction, receive-in-progress and last line state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            rx_busy_q <= 1'b0;
            line_q    <= LINE_J;
        end else begin
            dir_q <= ulpi_dir;
            if (ev.rx_start) begin
                rx_busy_q <= 1'b1;
            end else if (ev.rx_end) begin
                rx_busy_q <= 1'b0;
            end
            if (rxcmd_valid) begin
                line_q <= rxcmd_linestate;
            end
        end
    end

endmodule

// File: rtl/ulpi_ipd_gap.sv
// Module: inter-packet gap counter.
// Restarts on the speed-dependent reference event, latches the window for the
// speed seen at that moment, and raises permit once the window has elapsed.
// Permit then holds until the next bus event. force_open releases it early.
// Assumes: every window value fits in CNT_W bits and is at least 1.
module ulpi_ipd_gap
    import ulpi_ipd_pkg::*;
#(
    parameter int TT_HS = 15,
    parameter int RT_HS = 1,
    parameter int GAP_FS = 7,
    parameter int GAP_LS = 77,
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_mode,
    input  bus_ev_t    ev,
    input  logic       force_open,
    output logic       permit
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] lim_sel;
    logic             run_q;
    logic             permit_q;
    logic             hs;
    logic             restart;
    logic             hold;

    assign hs      = is_high_speed(speed_mode);
    assign restart = hs ? (ev.tx_end || ev.rx_end) : ev.se0_j;
    assign hold    = !hs && (ev.tx_end || ev.rx_end);
    assign cnt_nxt = cnt_q + CNT_W'(1);

    // Purpose: choose the window that a restart in this cycle would load
    always_comb begin
        if (hs) begin
            lim_sel = ev.tx_end ? CNT_W'(TT_HS) : CNT_W'(RT_HS);
        end else if (speed_mode == SPD_LS) begin
            lim_sel = CNT_W'(GAP_LS);
        end else begin
            lim_sel = CNT_W'(GAP_FS);
        end
    end

    // Purpose: gap counter and permit flag, highest priority first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            lim_q    <= CNT_W'(1);
            run_q    <= 1'b1;
            permit_q <= 1'b0;
        end else if (ev.rx_start) begin
            run_q    <= 1'b0;
            permit_q <= 1'b0;
        end else if (restart) begin
            cnt_q    <= '0;
            lim_q    <= lim_sel;
            run_q    <= 1'b1;
            permit_q <= 1'b0;
        end else if (hold) begin
            run_q    <= 1'b0;
            permit_q <= 1'b0;
        end else if (force_open) begin
            run_q    <= 1'b0;
            permit_q <= 1'b1;
        end else if (run_q) begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt >= lim_q) begin
                run_q    <= 1'b0;
                permit_q <= 1'b1;
            end
        end
    end

    assign permit = permit_q;

endmodule

// File: rtl/ulpi_ipd_resp.sv
// Module: response timer.
// Armed at every link transmit end with the timeout of the speed at that
// moment; cancelled by a receive start; emits a one-cycle timeout pulse.
// fire is the combinational form of the same event, for the gap counter.
// Assumes: every timeout value fits in CNT_W bits and is at least 1.
module ulpi_ipd_resp
    import ulpi_ipd_pkg::*;
#(
    parameter int TO_HS = 92,
    parameter int TO_FS = 80,
    parameter int TO_LS = 718,
    parameter int CNT_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_mode,
    input  logic       tx_end,
    input  logic       rx_start,
    output logic       fire,
    output logic       timeout
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] lim_sel;
    logic             run_q;
    logic             timeout_q;

    assign cnt_nxt = cnt_q + CNT_W'(1);
    assign fire    = run_q && !rx_start && !tx_end && (cnt_nxt == lim_q);

    // Purpose: timeout limit for the speed at the arming event
    always_comb begin
        if (is_high_speed(speed_mode)) begin
            lim_sel = CNT_W'(TO_HS);
        end else if (speed_mode == SPD_LS) begin
            lim_sel = CNT_W'(TO_LS);
        end else begin
            lim_sel = CNT_W'(TO_FS);
        end
    end

    // Purpose: arm, cancel and count the response window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            run_q     <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= fire;
            if (tx_end) begin
                cnt_q <= '0;
                lim_q <= lim_sel;
                run_q <= 1'b1;
            end else if (rx_start || fire) begin
                run_q <= 1'b0;
            end else if (run_q) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    assign timeout = timeout_q;

endmodule

// File: rtl/ulpi_ipd_rrmon.sv
// Module: receive-to-receive spacing monitor.
// Counts clocks since the last receive end (saturating) and flags a receive
// start that arrives before RR_MIN_GAP clocks have passed.
// Assumes: RR_MIN_GAP >= 1; a link transmit end forgets the previous receive.
module ulpi_ipd_rrmon
    import ulpi_ipd_pkg::*;
#(
    parameter int RR_MIN_GAP = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  bus_ev_t ev,
    output logic    too_close
);

    localparam int GW = $clog2(RR_MIN_GAP + 1);

    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic          flag_q;

    // Purpose: track separation since the last receive end and raise the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            flag_q <= ev.rx_start && seen_q && (gap_q < GW'(RR_MIN_GAP));
            if (ev.rx_end) begin
                gap_q  <= GW'(1);
                seen_q <= 1'b1;
            end else begin
                if (ev.rx_start || ev.tx_end) begin
                    seen_q <= 1'b0;
                end
                if (gap_q < GW'(RR_MIN_GAP)) begin
                    gap_q <= gap_q + GW'(1);
                end
            end
        end
    end

    assign too_close = flag_q;

endmodule

// File: rtl/ulpi_ipd_timer.sv
// Module: top of the ULPI link inter-packet delay timer.
// Joins the event decoder, gap counter, response timer and receive spacing
// monitor. Counter widths are derived from the largest configured limit.
// Assumes: one ULPI clock domain, synchronous active-low reset.
module ulpi_ipd_timer
    import ulpi_ipd_pkg::*;
#(
    parameter int TT_HS      = 15,
    parameter int RT_HS      = 1,
    parameter int GAP_FS     = 7,
    parameter int GAP_LS     = 77,
    parameter int TO_HS      = 92,
    parameter int TO_FS      = 80,
    parameter int TO_LS      = 718,
    parameter int RR_MIN_GAP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ulpi_dir,
    input  logic       ulpi_stp,
    input  logic       ulpi_nxt,
    input  logic       rxcmd_valid,
    input  logic [1:0] rxcmd_linestate,
    input  logic       rxcmd_rxactive,
    input  logic [1:0] speed_mode,
    output logic       tx_permit,
    output logic       resp_timeout,
    output logic       rx_gap_short
);

    localparam int GAP_MAX = imax(imax(TT_HS, RT_HS), imax(GAP_FS, GAP_LS));
    localparam int TO_MAX  = imax(TO_HS, imax(TO_FS, TO_LS));
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int TO_W    = $clog2(TO_MAX + 1);

    bus_ev_t ev_w;
    logic    fire_w;

    ulpi_ipd_evdec u_dec (
        .clk             (clk),
        .rst_n           (rst_n),
        .ulpi_dir        (ulpi_dir),
        .ulpi_stp        (ulpi_stp),
        .ulpi_nxt        (ulpi_nxt),
        .rxcmd_valid     (rxcmd_valid),
        .rxcmd_linestate (rxcmd_linestate),
        .rxcmd_rxactive  (rxcmd_rxactive),
        .ev              (ev_w)
    );

    ulpi_ipd_resp #(
        .TO_HS (TO_HS),
        .TO_FS (TO_FS),
        .TO_LS (TO_LS),
        .CNT_W (TO_W)
    ) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_mode (speed_mode),
        .tx_end     (ev_w.tx_end),
        .rx_start   (ev_w.rx_start),
        .fire       (fire_w),
        .timeout    (resp_timeout)
    );

    ulpi_ipd_gap #(
        .TT_HS  (TT_HS),
        .RT_HS  (RT_HS),
        .GAP_FS (GAP_FS),
        .GAP_LS (GAP_LS),
        .CNT_W  (GAP_W)
    ) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_mode (speed_mode),
        .ev         (ev_w),
        .force_open (fire_w),
        .permit     (tx_permit)
    );

    ulpi_ipd_rrmon #(
        .RR_MIN_GAP (RR_MIN_GAP)
    ) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev_w),
        .too_close (rx_gap_short)
    );

endmodule

// File: rtl/ulpi_ipd_timer_chk.sv
// Module: property checker for ulpi_ipd_timer, attached with bind below.
// Assumes: event inputs are the decoder's one-cycle event bits.
module ulpi_ipd_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] speed_mode,
    input logic       tx_permit,
    input logic       resp_timeout,
    input logic       rx_gap_short,
    input logic       ev_rx_start,
    input logic       ev_rx_end,
    input logic       ev_tx_end,
    input logic       ev_se0_j
);

    logic hs;
    assign hs = (speed_mode == 2'b00) || (speed_mode == 2'b11);

    // R2
    hs_tx_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_end && hs) |=> !tx_permit);

    // R4
    slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_tx_end || ev_rx_end) && !hs) |=> !tx_permit);

    // R6
    permit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_permit && !ev_rx_start && !ev_rx_end && !ev_tx_end && !(ev_se0_j && !hs))
        |=> tx_permit);

    // R7
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_start |=> !tx_permit);

    // R8
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_timeout |=> !resp_timeout);

    // R8
    timeout_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_timeout |-> tx_permit);

    // R10
    gap_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_gap_short |-> $past(ev_rx_start));

endmodule

bind ulpi_ipd_timer ulpi_ipd_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .speed_mode   (speed_mode),
    .tx_permit    (tx_permit),
    .resp_timeout (resp_timeout),
    .rx_gap_short (rx_gap_short),
    .ev_rx_start  (ev_w.rx_start),
    .ev_rx_end    (ev_w.rx_end),
    .ev_tx_end    (ev_w.tx_end),
    .ev_se0_j     (ev_w.se0_j)
);

// File: tb/ulpi_ipd_timer_bench.sv
`timescale 1ns/1ps
module ulpi_ipd_timer_bench;

    localparam int E_TT_HS = 15;
    localparam int E_RT_HS = 1;
    localparam int E_GAP_FS = 7;
    localparam int E_GAP_LS = 77;
    localparam int E_TO_HS = 92;
    localparam int E_TO_FS = 80;
    localparam int E_TO_LS = 718;
    localparam int E_RR = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ulpi_dir = 1'b0;
    logic       ulpi_stp = 1'b0;
    logic       ulpi_nxt = 1'b0;
    logic       rxcmd_valid = 1'b0;
    logic [1:0] rxcmd_linestate = 2'b01;
    logic       rxcmd_rxactive = 1'b0;
    logic [1:0] speed_mode = 2'b00;
    logic       tx_permit;
    logic       resp_timeout;
    logic       rx_gap_short;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ulpi_ipd_timer #(.RR_MIN_GAP(E_RR)) u_ulpi_ipd_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .ulpi_dir        (ulpi_dir),
        .ulpi_stp        (ulpi_stp),
        .ulpi_nxt        (ulpi_nxt),
        .rxcmd_valid     (rxcmd_valid),
        .rxcmd_linestate (rxcmd_linestate),
        .rxcmd_rxactive  (rxcmd_rxactive),
        .speed_mode      (speed_mode),
        .tx_permit       (tx_permit),
        .resp_timeout    (resp_timeout),
        .rx_gap_short    (rx_gap_short)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] spd);
        rst_n = 1'b0;
        ulpi_dir = 1'b0; ulpi_stp = 1'b0; ulpi_nxt = 1'b0;
        rxcmd_valid = 1'b0; rxcmd_linestate = 2'b01; rxcmd_rxactive = 1'b0;
        speed_mode = spd;
        tick(); tick();
        rst_n = 1'b1;
        tick(); tick();
    endtask

    task automatic wait_permit(output int n);
        n = 0;
        while (!tx_permit && n < 2000) begin
            tick();
            n++;
        end
    endtask

    task automatic ev_tx();
        ulpi_stp = 1'b1; tick(); ulpi_stp = 1'b0;
    endtask

    task automatic ev_se0j();
        rxcmd_valid = 1'b1; rxcmd_rxactive = 1'b0;
        rxcmd_linestate = 2'b00; tick();
        rxcmd_linestate = 2'b01; tick();
        rxcmd_valid = 1'b0;
    endtask

    function automatic bit hs_of(input logic [1:0] s);
        return (s == 2'b00) || (s == 2'b11);
    endfunction

    function automatic int slow_gap(input logic [1:0] s);
        return (s == 2'b10) ? E_GAP_LS : E_GAP_FS;
    endfunction

    function automatic int to_of(input logic [1:0] s);
        if (hs_of(s)) return E_TO_HS;
        return (s == 2'b10) ? E_TO_LS : E_TO_FS;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        int bad;
        bit pb;

        // R1: reset state and first edge after release
        rst_n = 1'b0;
        tick(); tick();
        check("R1 permit in reset", int'(tx_permit), 0);
        check("R1 timeout in reset", int'(resp_timeout), 0);
        check("R1 gap flag in reset", int'(rx_gap_short), 0);
        rst_n = 1'b1;
        check("R1 permit before first edge", int'(tx_permit), 0);
        tick();
        check("R1 permit after first edge", int'(tx_permit), 1);

        // R2 R3 R4 R7: sweep speeds and gap event kinds
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 3; k++) begin
                do_reset(2'(s));
                if (k == 0) begin
                    ev_tx();
                end else if (k == 1) begin
                    ulpi_dir = 1'b1; ulpi_nxt = 1'b1; tick(); ulpi_nxt = 1'b0;
                    check("R7 dir+nxt start drops permit", int'(tx_permit), 0);
                    tick(); tick();
                    ulpi_dir = 1'b0; tick();
                end else begin
                    ulpi_dir = 1'b1; tick();
                    check("R7 dir rise without nxt keeps permit", int'(tx_permit), 1);
                    rxcmd_valid = 1'b1; rxcmd_rxactive = 1'b1; tick();
                    check("R7 rxcmd start drops permit", int'(tx_permit), 0);
                    rxcmd_rxactive = 1'b0; tick();
                    rxcmd_valid = 1'b0;
                end
                if (hs_of(2'(s))) begin
                    wait_permit(n);
                    check(k == 0 ? "R2 hs tx gap" : "R3 hs rx gap", n,
                          k == 0 ? E_TT_HS : E_RT_HS);
                end else begin
                    repeat (20) tick();
                    check("R4 slow hold before se0-j", int'(tx_permit), 0);
                    ev_se0j();
                    wait_permit(n);
                    check("R4 slow gap from se0-j", n, slow_gap(2'(s)));
                end
            end
        end

        // R5: speed change after the restart does not alter gap or timeout
        do_reset(2'b00);
        ev_tx();
        repeat (3) tick();
        speed_mode = 2'b10;
        wait_permit(n);
        check("R5 latched hs gap", n + 3, E_TT_HS);
        n = n + 3;
        while (!resp_timeout && n < 2000) begin tick(); n++; end
        check("R5 latched hs timeout", n, E_TO_HS);

        // R8: timeout per speed, one-cycle pulse, permit released
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            ev_tx();
            n = 0;
            pb = tx_permit;
            while (!resp_timeout && n < 2000) begin
                pb = tx_permit;
                tick();
                n++;
            end
            check("R8 timeout delay", n, to_of(2'(s)));
            check("R8 permit before timeout", int'(pb), hs_of(2'(s)) ? 1 : 0);
            check("R8 permit at timeout", int'(tx_permit), 1);
            tick();
            check("R8 single pulse", int'(resp_timeout), 0);
        end

        // R9: receive start cancels the timeout; R3 via dir fall afterwards
        do_reset(2'b00);
        ev_tx();
        repeat (30) tick();
        ulpi_dir = 1'b1; ulpi_nxt = 1'b1; tick(); ulpi_nxt = 1'b0;
        bad = 0;
        n = 0;
        for (int i = 0; i < 800; i++) begin
            tick();
            if (resp_timeout) bad++;
            if (tx_permit) n++;
        end
        check("R9 no timeout after rx start", bad, 0);
        check("R7 permit low during receive", n, 0);
        ulpi_dir = 1'b0; tick();
        wait_permit(n);
        check("R3 dir fall gap", n, E_RT_HS);

        // R6: permit holds with no events
        do_reset(2'b01);
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (!tx_permit) bad++;
        end
        check("R6 permit holds", bad, 0);

        // R10: receive-to-receive spacing
        do_reset(2'b00);
        ulpi_dir = 1'b1; tick();
        rxcmd_valid = 1'b1; rxcmd_rxactive = 1'b1; tick();
        check("R10 first receive not flagged", int'(rx_gap_short), 0);
        rxcmd_rxactive = 1'b0; tick();
        rxcmd_rxactive = 1'b1; tick();
        check("R10 gap of 1 flagged", int'(rx_gap_short), 1);
        rxcmd_valid = 1'b0; tick();
        check("R10 flag is one pulse", int'(rx_gap_short), 0);
        rxcmd_valid = 1'b1; rxcmd_rxactive = 1'b0; tick();
        rxcmd_valid = 1'b0; tick();
        rxcmd_valid = 1'b1; rxcmd_rxactive = 1'b1; tick();
        check("R10 gap of 2 not flagged", int'(rx_gap_short), 0);
        rxcmd_valid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule